// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block sits on the primary side of a PCI-to-PCI bridge and decides, for each transaction address that arrives, whether the bridge must claim it and forward it to the secondary bus. It rebuilds three forwarding windows from the packed base and limit configuration fields: I/O, non-prefetchable memory and prefetchable memory. It gates them with the command-register enables and adds the fixed legacy display ranges when the display-forwarding control bit is set.

The reconstructed base and limit of every window are driven out combinationally so that neighbouring logic, such as an address translator, can use them. Each address strobe produces one registered result a cycle later. The result says whether the address hit and names the window that claimed it.

Top module: `bridge_window_decoder`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `hit_valid`, `hit` and `hit_win` are all zero.
- R2: I/O window: the base is `io_base_reg[7:4]` placed at bits 15:12 with bits 11:0 zero, and the limit is `io_limit_reg[7:4]` at bits 15:12 with bits 11:0 all ones. When a register's low nibble equals 4'h1, its 16-bit upper register (`io_base_hi` / `io_limit_hi`) fills bits 31:16. Otherwise those bits are zero.
- R3: Memory window: the base is `mem_base_reg[15:4]` at bits 31:20 with bits 19:0 zero, and the limit is `mem_limit_reg[15:4]` at bits 31:20 with bits 19:0 all ones. The low nibble of either register has no effect.
- R4: Prefetchable window: the base and limit are built as in R3 from `pf_base_reg` / `pf_limit_reg`. When a register's low nibble equals 4'h1, the 32-bit upper register (`pf_base_hi` / `pf_limit_hi`) fills bits 63:32. Otherwise bits 63:32 are zero.
- R5: An address hits a window when base <= addr <= limit, within the window's own space. `req_is_io`=1 selects the I/O space and `req_is_io`=0 selects the memory space. The I/O and non-prefetchable memory windows only match addresses whose bits 63:32 are zero.
- R6: `io_en`=0 stops the I/O window from matching. `mem_en`=0 stops both the memory and the prefetchable windows from matching.
- R7: A window whose limit is below its base matches nothing. A window whose base and limit registers are equal spans one full granule.
- R8: When `vga_en`=1, the block also forwards memory addresses 0xA0000–0xBFFFF and I/O addresses 0x3B0–0x3BB and 0x3C0–0x3DF. These ranges do not depend on `io_en` or `mem_en`, and they are not forwarded when `vga_en`=0.
- R9: The result appears on the clock edge after the strobe. `hit_valid` is high for exactly one cycle. `hit_win` is encoded as 0 none, 1 I/O, 2 memory, 3 prefetchable, 4 display, and `hit` is 1 exactly when `hit_win` is non-zero.
- R10: When several windows match, the I/O window beats the display range in I/O space. In memory space, the memory window beats the prefetchable window, and the prefetchable window beats the display range.
- R11: In a cycle after one with `req_valid`=0, `hit_valid`, `hit` and `hit_win` are zero, even if the address would hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_base_reg | input | 8 | Packed I/O base field, low nibble = type |
| io_limit_reg | input | 8 | Packed I/O limit field, low nibble = type |
| io_base_hi | input | 16 | Upper 16 bits of I/O base |
| io_limit_hi | input | 16 | Upper 16 bits of I/O limit |
| mem_base_reg | input | 16 | Packed memory base field |
| mem_limit_reg | input | 16 | Packed memory limit field |
| pf_base_reg | input | 16 | Packed prefetchable base field, low nibble = type |
| pf_limit_reg | input | 16 | Packed prefetchable limit field, low nibble = type |
| pf_base_hi | input | 32 | Upper 32 bits of prefetchable base |
| pf_limit_hi | input | 32 | Upper 32 bits of prefetchable limit |
| io_en | input | 1 | Command I/O space enable |
| mem_en | input | 1 | Command memory space enable |
| vga_en | input | 1 | Legacy display forwarding enable |
| req_valid | input | 1 | Address strobe |
| req_addr | input | 64 | Transaction address |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| hit_valid | output | 1 | Registered result valid |
| hit | output | 1 | Registered forward decision |
| hit_win | output | 3 | Registered claiming window |
| io_base_o | output | 32 | Decoded I/O base |
| io_limit_o | output | 32 | Decoded I/O limit |
| mem_base_o | output | 32 | Decoded memory base |
| mem_limit_o | output | 32 | Decoded memory limit |
| pf_base_o | output | 64 | Decoded prefetchable base |
| pf_limit_o | output | 64 | Decoded prefetchable limit |

## Verification
The hardest situation to reach is several windows claiming the same address at once, because the order of precedence only shows when they overlap. The stimulus programs the memory, prefetchable and I/O windows to cover the low megabyte and switches display forwarding on. It then empties one window at a time and checks which window claims the address after each step. The bench also places inverted windows and one-granule windows at their exact edges, so that off-by-one errors in the compare or in the filling of the limit bits show up.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    typedef enum logic [2:0] {
        WIN_NONE = 3'd0,
        WIN_IO   = 3'd1,
        WIN_MEM  = 3'd2,
        WIN_PREF = 3'd3,
        WIN_VGA  = 3'd4
    } win_e;

    typedef struct packed {
        logic valid;
        logic hit;
        win_e win;
    } result_t;
endpackage

// File: rtl/bwd_range_match.sv
module bwd_range_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    input  logic         enable,
    output logic         match
);
    logic non_empty;
    always_comb begin
        non_empty = (limit >= base);
        match     = enable && non_empty && (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/bwd_legacy_match.sv
module bwd_legacy_match #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] addr,
    input  logic          is_io,
    input  logic          enable,
    output logic          match
);
    localparam logic [AW-1:0] MEM_LO  = AW'(20'hA0000);
    localparam logic [AW-1:0] MEM_HI  = AW'(20'hBFFFF);
    localparam logic [AW-1:0] IOA_LO  = AW'(12'h3B0);
    localparam logic [AW-1:0] IOA_HI  = AW'(12'h3BB);
    localparam logic [AW-1:0] IOB_LO  = AW'(12'h3C0);
    localparam logic [AW-1:0] IOB_HI  = AW'(12'h3DF);

    logic in_mem, in_ioa, in_iob;
    always_comb begin
        in_mem = (addr >= MEM_LO) && (addr <= MEM_HI);
        in_ioa = (addr >= IOA_LO) && (addr <= IOA_HI);
        in_iob = (addr >= IOB_LO) && (addr <= IOB_HI);
        match  = enable && (is_io ? (in_ioa || in_iob) : in_mem);
    end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int IO_W      = 32,
    parameter int MEM_W     = 32,
    parameter int IO_GRAN   = 12,
    parameter int MEM_GRAN  = 20,
    parameter int IOREG_W   = 8,
    parameter int MEMREG_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IOREG_W-1:0]  io_base_reg,
    input  logic [IOREG_W-1:0]  io_limit_reg,
    input  logic [IO_W-17:0]    io_base_hi,
    input  logic [IO_W-17:0]    io_limit_hi,
    input  logic [MEMREG_W-1:0] mem_base_reg,
    input  logic [MEMREG_W-1:0] mem_limit_reg,
    input  logic [MEMREG_W-1:0] pf_base_reg,
    input  logic [MEMREG_W-1:0] pf_limit_reg,
    input  logic [ADDR_W-33:0]  pf_base_hi,
    input  logic [ADDR_W-33:0]  pf_limit_hi,
    input  logic                io_en,
    input  logic                mem_en,
    input  logic                vga_en,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_is_io,
    output logic                hit_valid,
    output logic                hit,
    output logic [2:0]          hit_win,
    output logic [IO_W-1:0]     io_base_o,
    output logic [IO_W-1:0]     io_limit_o,
    output logic [MEM_W-1:0]    mem_base_o,
    output logic [MEM_W-1:0]    mem_limit_o,
    output logic [ADDR_W-1:0]   pf_base_o,
    output logic [ADDR_W-1:0]   pf_limit_o
);
    localparam int          IO_FLD  = 16 - IO_GRAN;
    localparam int          MEM_FLD = 32 - MEM_GRAN;
    localparam logic [3:0]  WIDE_TYPE = 4'h1;

    // ---- window reconstruction from packed fields ----
    logic io_b_wide, io_l_wide, pf_b_wide, pf_l_wide;
    always_comb begin
        io_b_wide = (io_base_reg[3:0]  == WIDE_TYPE);
        io_l_wide = (io_limit_reg[3:0] == WIDE_TYPE);
        pf_b_wide = (pf_base_reg[3:0]  == WIDE_TYPE);
        pf_l_wide = (pf_limit_reg[3:0] == WIDE_TYPE);

        io_base_o   = {(io_b_wide ? io_base_hi  : '0), io_base_reg[IOREG_W-1 -: IO_FLD],  {IO_GRAN{1'b0}}};
        io_limit_o  = {(io_l_wide ? io_limit_hi : '0), io_limit_reg[IOREG_W-1 -: IO_FLD], {IO_GRAN{1'b1}}};
        mem_base_o  = {mem_base_reg[MEMREG_W-1 -: MEM_FLD],  {MEM_GRAN{1'b0}}};
        mem_limit_o = {mem_limit_reg[MEMREG_W-1 -: MEM_FLD], {MEM_GRAN{1'b1}}};
        pf_base_o   = {(pf_b_wide ? pf_base_hi  : '0), pf_base_reg[MEMREG_W-1 -: MEM_FLD],  {MEM_GRAN{1'b0}}};
        pf_limit_o  = {(pf_l_wide ? pf_limit_hi : '0), pf_limit_reg[MEMREG_W-1 -: MEM_FLD], {MEM_GRAN{1'b1}}};
    end

    // ---- per-window matching ----
    logic upper_zero;
    logic io_m, mem_m, pf_m, vga_m;
    assign upper_zero = (req_addr[ADDR_W-1:32] == '0);

    bwd_range_match #(.W(IO_W)) u_io (
        .addr(req_addr[IO_W-1:0]), .base(io_base_o), .limit(io_limit_o),
        .enable(io_en && req_is_io && upper_zero), .match(io_m));

    bwd_range_match #(.W(MEM_W)) u_mem (
        .addr(req_addr[MEM_W-1:0]), .base(mem_base_o), .limit(mem_limit_o),
        .enable(mem_en && !req_is_io && upper_zero), .match(mem_m));

    bwd_range_match #(.W(ADDR_W)) u_pf (
        .addr(req_addr), .base(pf_base_o), .limit(pf_limit_o),
        .enable(mem_en && !req_is_io), .match(pf_m));

    bwd_legacy_match #(.AW(ADDR_W)) u_vga (
        .addr(req_addr), .is_io(req_is_io), .enable(vga_en), .match(vga_m));

    // ---- two-process result register ----
    result_t res_d, res_q;

    always_comb begin
        res_d       = '0;
        res_d.win   = WIN_NONE;
        if (req_valid) begin
            res_d.valid = 1'b1;
            if (req_is_io) begin
                if (io_m)       res_d.win = WIN_IO;
                else if (vga_m) res_d.win = WIN_VGA;
            end else begin
                if (mem_m)      res_d.win = WIN_MEM;
                else if (pf_m)  res_d.win = WIN_PREF;
                else if (vga_m) res_d.win = WIN_VGA;
            end
            res_d.hit = (res_d.win != WIN_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign hit_valid = res_q.valid;
    assign hit       = res_q.hit;
    assign hit_win   = res_q.win;

    // ---- assertions ----
    assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> hit_valid);
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!hit_valid && !hit && hit_win == 3'd0));
    assert_hit_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (hit_win != 3'd0));
    assert_io_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io && !io_en && !vga_en) |=> !hit);
    assert_mem_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io && !mem_en && !vga_en) |=> !hit);
    assert_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_io) |=> (hit_win != 3'd2 && hit_win != 3'd3));
    assert_iospace_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_io) |=> (hit_win != 3'd1));
endmodule

// File: tb/sim_bridge_window_decoder.sv
module sim_bridge_window_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  io_base_reg, io_limit_reg;
    logic [15:0] io_base_hi, io_limit_hi;
    logic [15:0] mem_base_reg, mem_limit_reg, pf_base_reg, pf_limit_reg;
    logic [31:0] pf_base_hi, pf_limit_hi;
    logic        io_en, mem_en, vga_en, req_valid, req_is_io;
    logic [63:0] req_addr;
    logic        hit_valid, hit;
    logic [2:0]  hit_win;
    logic [31:0] io_base_o, io_limit_o, mem_base_o, mem_limit_o;
    logic [63:0] pf_base_o, pf_limit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_window_decoder u0 (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic close_all();
        @(negedge clk);
        io_base_reg = 8'hF0;  io_limit_reg = 8'h00; io_base_hi = '0; io_limit_hi = '0;
        mem_base_reg = 16'hFFF0; mem_limit_reg = 16'h0000;
        pf_base_reg = 16'hFFF0;  pf_limit_reg = 16'h0000; pf_base_hi = '0; pf_limit_hi = '0;
        io_en = 1'b1; mem_en = 1'b1; vga_en = 1'b0;
    endtask

    task automatic send(input string req, input logic [63:0] a, input logic io,
                        input logic [2:0] exp_win);
        @(negedge clk);
        req_addr = a; req_is_io = io; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {63'd0, hit_valid}, 64'd1);
        check(req, {61'd0, hit_win}, {61'd0, exp_win});
        check(req, {63'd0, hit}, {63'd0, exp_win != 3'd0});
        @(negedge clk);
        check("R11 idle", {60'd0, hit_valid, hit, hit_win}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 reset", {60'd0, hit_valid, hit, hit_win}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {60'd0, hit_valid, hit, hit_win}, 64'd0);
    endtask

    task automatic t_io();
        close_all();
        io_base_reg = 8'h20; io_limit_reg = 8'h30; io_base_hi = 16'h0007;
        #1;
        check("R2 io base 16", {32'd0, io_base_o}, 64'h2000);
        check("R2 io limit 16", {32'd0, io_limit_o}, 64'h3FFF);
        send("R5 io low edge", 64'h2000, 1'b1, 3'd1);
        send("R5 io high edge", 64'h3FFF, 1'b1, 3'd1);
        send("R5 io below", 64'h1FFF, 1'b1, 3'd0);
        send("R5 io above", 64'h4000, 1'b1, 3'd0);
        send("R5 io addr in mem space", 64'h2000, 1'b0, 3'd0);
        @(negedge clk);
        io_base_reg = 8'h21; io_limit_reg = 8'h21; io_base_hi = 16'h0005; io_limit_hi = 16'h0005;
        #1;
        check("R2 io base 32", {32'd0, io_base_o}, 64'h0005_2000);
        check("R2 io limit 32", {32'd0, io_limit_o}, 64'h0005_2FFF);
        send("R2 io32 hit", 64'h0005_2FFF, 1'b1, 3'd1);
        send("R2 io32 upper mismatch", 64'h2FFF, 1'b1, 3'd0);
    endtask

    task automatic t_mem();
        close_all();
        mem_base_reg = 16'h800A; mem_limit_reg = 16'h80F5;
        #1;
        check("R3 mem base", {32'd0, mem_base_o}, 64'h8000_0000);
        check("R3 mem limit", {32'd0, mem_limit_o}, 64'h80FF_FFFF);
        send("R5 mem low edge", 64'h8000_0000, 1'b0, 3'd2);
        send("R5 mem high edge", 64'h80FF_FFFF, 1'b0, 3'd2);
        send("R5 mem above", 64'h8100_0000, 1'b0, 3'd0);
        send("R5 mem upper bits set", 64'h1_8000_0000, 1'b0, 3'd0);
    endtask

    task automatic t_pref();
        close_all();
        pf_base_reg = 16'hC001; pf_limit_reg = 16'hC011; pf_base_hi = 32'h1; pf_limit_hi = 32'h1;
        #1;
        check("R4 pref base 64", pf_base_o, 64'h1_C000_0000);
        check("R4 pref limit 64", pf_limit_o, 64'h1_C01F_FFFF);
        send("R4 pref hit", 64'h1_C000_0000, 1'b0, 3'd3);
        send("R4 pref edge", 64'h1_C01F_FFFF, 1'b0, 3'd3);
        send("R4 pref miss low half", 64'hC000_0000, 1'b0, 3'd0);
        @(negedge clk);
        pf_base_reg = 16'hC000; pf_limit_reg = 16'hC010;
        #1;
        check("R4 pref base 32", pf_base_o, 64'hC000_0000);
        check("R4 pref limit 32", pf_limit_o, 64'hC01F_FFFF);
        send("R4 pref32 hit", 64'hC000_1000, 1'b0, 3'd3);
    endtask

    task automatic t_empty();
        close_all();
        mem_base_reg = 16'h9000; mem_limit_reg = 16'h8000;
        send("R7 inverted at limit", 64'h8000_0000, 1'b0, 3'd0);
        send("R7 inverted at base", 64'h9000_0000, 1'b0, 3'd0);
        @(negedge clk);
        mem_limit_reg = 16'h9000;
        send("R7 one granule top", 64'h900F_FFFF, 1'b0, 3'd2);
        send("R7 one granule past", 64'h9010_0000, 1'b0, 3'd0);
    endtask

    task automatic t_gate();
        close_all();
        io_base_reg = 8'h10; io_limit_reg = 8'h10;
        mem_base_reg = 16'h4000; mem_limit_reg = 16'h4000;
        pf_base_reg = 16'h5000; pf_limit_reg = 16'h5000;
        io_en = 1'b0;
        send("R6 io disabled", 64'h1000, 1'b1, 3'd0);
        send("R6 mem on while io off", 64'h4000_0000, 1'b0, 3'd2);
        @(negedge clk); io_en = 1'b1; mem_en = 1'b0;
        send("R6 mem disabled", 64'h4000_0000, 1'b0, 3'd0);
        send("R6 pref disabled", 64'h5000_0000, 1'b0, 3'd0);
        send("R6 io on while mem off", 64'h1000, 1'b1, 3'd1);
    endtask

    task automatic t_vga();
        close_all();
        io_en = 1'b0; mem_en = 1'b0; vga_en = 1'b1;
        send("R8 vga mem low", 64'hA0000, 1'b0, 3'd4);
        send("R8 vga mem high", 64'hBFFFF, 1'b0, 3'd4);
        send("R8 vga mem below", 64'h9FFFF, 1'b0, 3'd0);
        send("R8 vga mem above", 64'hC0000, 1'b0, 3'd0);
        send("R8 vga io a low", 64'h3B0, 1'b1, 3'd4);
        send("R8 vga io a high", 64'h3BB, 1'b1, 3'd4);
        send("R8 vga io gap", 64'h3BC, 1'b1, 3'd0);
        send("R8 vga io b low", 64'h3C0, 1'b1, 3'd4);
        send("R8 vga io b high", 64'h3DF, 1'b1, 3'd4);
        send("R8 vga io above", 64'h3E0, 1'b1, 3'd0);
        send("R8 io range in mem space", 64'h3C0, 1'b0, 3'd0);
        @(negedge clk); vga_en = 1'b0;
        send("R8 vga off", 64'hA0000, 1'b0, 3'd0);
    endtask

    task automatic t_prio();
        close_all();
        vga_en = 1'b1;
        mem_base_reg = 16'h0000; mem_limit_reg = 16'h0000;
        pf_base_reg = 16'h0000;  pf_limit_reg = 16'h0000;
        io_base_reg = 8'h00;     io_limit_reg = 8'h00;
        send("R10 mem over pref and vga", 64'hA0000, 1'b0, 3'd2);
        @(negedge clk); mem_base_reg = 16'hFFF0;
        send("R10 pref over vga", 64'hA0000, 1'b0, 3'd3);
        @(negedge clk); pf_base_reg = 16'hFFF0;
        send("R10 vga last", 64'hA0000, 1'b0, 3'd4);
        send("R10 io over vga", 64'h3C0, 1'b1, 3'd1);
    endtask

    task automatic t_idle();
        close_all();
        vga_en = 1'b1;
        @(negedge clk); req_addr = 64'hA0000; req_is_io = 1'b0; req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R11 no strobe", {60'd0, hit_valid, hit, hit_win}, 64'd0);
        end
    endtask

    initial begin
        req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0;
        io_base_reg = '0; io_limit_reg = '0; io_base_hi = '0; io_limit_hi = '0;
        mem_base_reg = '0; mem_limit_reg = '0; pf_base_reg = '0; pf_limit_reg = '0;
        pf_base_hi = '0; pf_limit_hi = '0; io_en = 1'b0; mem_en = 1'b0; vga_en = 1'b0;
        @(negedge clk); @(negedge clk);
        t_reset();
        t_io();
        t_mem();
        t_pref();
        t_empty();
        t_gate();
        t_vga();
        t_prio();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule